// File: doc/BRIEF.md
# Network Controller Interrupt Aggregator

This block gathers the interrupt sources of a small Ethernet controller into a single active-low interrupt output. Each source sets a flag when it pulses for one clock cycle. The sources are receive error, transmit error, transmit done, DMA done and PHY link change. An 8-bit enable register masks the flags, and a global enable bit gates the output pin. A read-only status bit shows whether any enabled flag is pending, and it does this whatever the global enable says.

The flags clear in different ways:
- The DMA-done, transmit-done, transmit-error and receive-error flags are cleared by the host with a bit-clear write.
- The packet-pending flag follows an internal count of unprocessed received packets. The count saturates and never wraps.
- The link-change flag clears only when the host reads the PHY flag register.
- The PHY flag register holds two flags that clear themselves when read. Two PHY enable bits qualify them.

The host reaches every register through a plain read/write port. Read data is combinational and returns the value from before any side effect of the read. The side effects of a read take place at the clock edge that ends the access.

Top module: `nic_irq_aggr`

## Requirements
- R1: After reset all enables, all flags and the packet count are 0, and `irq_n` is 1. Register addresses: 0 enable, 1 flags, 2 status, 3 PHY enable, 4 PHY flags, 5 packet count.
- R2: `irq_n` is 0 exactly when enable bit 7 (global) is 1 and some flag bit is 1 together with its own enable bit. While bit 7 is 0, `irq_n` stays 1.
- R3: Status bit 7 is 1 exactly when some flag bit and its own enable bit are both 1, whatever the global enable is. All other status bits read 0.
- R4: Flag bits 5 (DMA done), 3 (transmit done), 1 (transmit error) and 0 (receive error) are set by their event pulses. A write to address 1 clears each of these bits where the write data holds a 1. Such a write never sets a flag.
- R5: When a set event and a host clear of the same flag fall in the same cycle, the flag ends up set.
- R6: Flag bit 6 is 1 exactly while the packet count is nonzero. A received-packet pulse adds 1 to the count. A decrement pulse subtracts 1, and does nothing at 0. Writes to address 1 do not affect bit 6.
- R7: The packet count saturates at 255. A received-packet pulse at 255 leaves the count at 255 and sets flag bit 0. A no-space abort pulse also sets flag bit 0. If a received-packet pulse and a decrement arrive together at 255, the count becomes 254.
- R8: Flag bit 4 (link change) sets when a PHY link change occurs while both PHY enable bits are 1. It clears only through a read of address 4. Writes to address 1 leave it unchanged.
- R9: PHY flag bit 4 sets on every link change. PHY flag bit 2 sets only when a link change occurs while PHY enable bits 4 and 1 are both 1. A read of address 4 clears both bits.
- R10: If a link change arrives in the same cycle as a read of address 4, the read returns the old value, and the flags hold the new event afterwards.
- R11: Enable bit 2, flag bits 7 and 2, and every PHY enable bit other than 4 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ev_rx_nospace | input | 1 | Incoming packet aborted for lack of buffer space |
| ev_pkt_rcvd | input | 1 | Packet received into the buffer |
| ev_pkt_dec | input | 1 | Host consumed one packet |
| ev_tx_err | input | 1 | Transmit error pulse |
| ev_tx_done | input | 1 | Transmit request finished |
| ev_dma_done | input | 1 | DMA operation finished |
| ev_link_chg | input | 1 | PHY link status changed |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
A flag that is stuck or lost shows on the flag register at the next read. It also shows on `irq_n` and the status bit in the first cycle after the event, as soon as the matching enable is set. A packet count that wraps instead of saturating shows on the count register at once. It also shows as a missing receive-error flag, and as a packet-pending flag that drops too early. A PHY flag that fails to clear on read, or a link flag that clears the wrong way, shows on the very next read of address 4 or address 1.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int REG_W  = 16;
  localparam int FLAG_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_ENABLE  = 3'd0,
    A_FLAGS   = 3'd1,
    A_STATUS  = 3'd2,
    A_PHY_EN  = 3'd3,
    A_PHY_FLG = 3'd4,
    A_PKT_CNT = 3'd5
  } reg_addr_e;

  // Bit positions shared by the enable and flag registers
  localparam int B_GLOBAL = 7;
  localparam int B_PKT    = 6;
  localparam int B_DMA    = 5;
  localparam int B_LINK   = 4;
  localparam int B_TXDONE = 3;
  localparam int B_TXERR  = 1;
  localparam int B_RXERR  = 0;

  // PHY register bit positions
  localparam int P_LINK   = 4;
  localparam int P_GLOBAL_EN  = 1;
  localparam int P_GLOBAL_FLG = 2;

  localparam logic [FLAG_W-1:0] ENABLE_MASK = 8'hFB;
  localparam logic [FLAG_W-1:0] CLR_MASK    = 8'h2B;
  localparam logic [REG_W-1:0]  PHY_EN_MASK = 16'h0012;
endpackage

// File: rtl/nic_irq_pktcnt.sv
module nic_irq_pktcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count,
  output logic             overflow_abort
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty, inc_ok, dec_ok, cnt_en;

  always_comb begin
    full   = (cnt_q == CNT_MAX);
    empty  = (cnt_q == '0);
    inc_ok = inc && !full;
    dec_ok = dec && !empty;
    cnt_en = inc_ok ^ dec_ok;
    cnt_d  = inc_ok ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count          = cnt_q;
  assign overflow_abort = inc && full;
endmodule

// File: rtl/nic_irq_phy.sv
module nic_irq_phy
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic [REG_W-1:0] wdata,
  input  logic             flg_rd,
  input  logic             link_chg,
  output logic [REG_W-1:0] phy_en,
  output logic [REG_W-1:0] phy_flg,
  output logic             global_set
);
  logic [REG_W-1:0] en_q, en_d;
  logic             lnk_q, lnk_d, glb_q, glb_d, flg_en;

  always_comb begin
    en_d       = wdata & PHY_EN_MASK;
    global_set = link_chg && en_q[P_LINK] && en_q[P_GLOBAL_EN];
    lnk_d      = link_chg   || (lnk_q && !flg_rd);
    glb_d      = global_set || (glb_q && !flg_rd);
    flg_en     = flg_rd || link_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lnk_q <= 1'b0;
      glb_q <= 1'b0;
    end else if (flg_en) begin
      lnk_q <= lnk_d;
      glb_q <= glb_d;
    end
  end

  always_comb begin
    phy_en               = en_q;
    phy_flg              = '0;
    phy_flg[P_LINK]      = lnk_q;
    phy_flg[P_GLOBAL_FLG] = glb_q;
  end
endmodule

// File: rtl/nic_irq_flags.sv
module nic_irq_flags
  import nic_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_data,
  input  logic [FLAG_W-1:0] hw_set,
  input  logic              link_set,
  input  logic              phy_rd,
  input  logic              pkt_pending,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] clr_q, clr_d, clr_vec;
  logic              link_q, link_d, link_en;

  always_comb begin
    clr_vec = clr_we ? (clr_data & CLR_MASK) : '0;
    clr_d   = ((clr_q & ~clr_vec) | hw_set) & CLR_MASK;
    link_d  = link_set || (link_q && !phy_rd);
    link_en = link_set || phy_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= '0;
    else        clr_q <= clr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       link_q <= 1'b0;
    else if (link_en) link_q <= link_d;
  end

  always_comb begin
    flags         = clr_q;
    flags[B_LINK] = link_q;
    flags[B_PKT]  = pkt_pending;
  end
endmodule

// File: rtl/nic_irq_aggr.sv
module nic_irq_aggr
  import nic_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ev_rx_nospace,
  input  logic        ev_pkt_rcvd,
  input  logic        ev_pkt_dec,
  input  logic        ev_tx_err,
  input  logic        ev_tx_done,
  input  logic        ev_dma_done,
  input  logic        ev_link_chg,
  output logic        irq_n
);
  logic [FLAG_W-1:0] en_q, en_d, flags, hw_set;
  logic              en_we, clr_we, phy_en_we, phy_rd, global_set;
  logic              pend_any, abort_full;
  logic [CNT_W-1:0]  pkt_cnt;
  logic [REG_W-1:0]  phy_en, phy_flg;

  always_comb begin
    en_we     = reg_wr && (reg_addr == A_ENABLE);
    clr_we    = reg_wr && (reg_addr == A_FLAGS);
    phy_en_we = reg_wr && (reg_addr == A_PHY_EN);
    phy_rd    = reg_rd && (reg_addr == A_PHY_FLG);
    en_d      = reg_wdata[FLAG_W-1:0] & ENABLE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  nic_irq_pktcnt #(.CNT_W(CNT_W)) u_pktcnt (
    .clk            (clk),
    .rst_n          (rst_n),
    .inc            (ev_pkt_rcvd),
    .dec            (ev_pkt_dec),
    .count          (pkt_cnt),
    .overflow_abort (abort_full)
  );

  nic_irq_phy u_phy (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_we      (phy_en_we),
    .wdata      (reg_wdata),
    .flg_rd     (phy_rd),
    .link_chg   (ev_link_chg),
    .phy_en     (phy_en),
    .phy_flg    (phy_flg),
    .global_set (global_set)
  );

  always_comb begin
    hw_set           = '0;
    hw_set[B_DMA]    = ev_dma_done;
    hw_set[B_TXDONE] = ev_tx_done;
    hw_set[B_TXERR]  = ev_tx_err;
    hw_set[B_RXERR]  = ev_rx_nospace || abort_full;
  end

  nic_irq_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_we      (clr_we),
    .clr_data    (reg_wdata[FLAG_W-1:0]),
    .hw_set      (hw_set),
    .link_set    (global_set),
    .phy_rd      (phy_rd),
    .pkt_pending (pkt_cnt != '0),
    .flags       (flags)
  );

  always_comb begin
    pend_any = |(flags[B_GLOBAL-1:0] & en_q[B_GLOBAL-1:0]);
    irq_n    = !(en_q[B_GLOBAL] && pend_any);
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_ENABLE:  reg_rdata[FLAG_W-1:0] = en_q;
      A_FLAGS:   reg_rdata[FLAG_W-1:0] = flags;
      A_STATUS:  reg_rdata[B_GLOBAL]   = pend_any;
      A_PHY_EN:  reg_rdata             = phy_en;
      A_PHY_FLG: reg_rdata             = phy_flg;
      A_PKT_CNT: reg_rdata[CNT_W-1:0]  = pkt_cnt;
      default:   reg_rdata             = '0;
    endcase
  end
endmodule

// File: rtl/nic_irq_aggr_chk.sv
module nic_irq_aggr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_n,
  input logic [7:0]       en_q,
  input logic [7:0]       flags,
  input logic [CNT_W-1:0] pkt_cnt,
  input logic [15:0]      phy_flg,
  input logic             phy_rd,
  input logic             ev_pkt_rcvd,
  input logic             ev_pkt_dec,
  input logic             ev_dma_done,
  input logic             ev_link_chg
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_global_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[7] |-> irq_n);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dma_done |=> flags[5]);

  p_pkt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[6] && !ev_pkt_dec) |=> flags[6]);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_cnt == CMAX && !ev_pkt_dec) |=> pkt_cnt == CMAX);

  p_link_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[4] && !phy_rd) |=> flags[4]);

  p_phy_selfclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rd && !ev_link_chg) |=> (phy_flg[4] == 1'b0 && phy_flg[2] == 1'b0));

  p_phy_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_chg |=> phy_flg[4]);

  p_pkt_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pkt_rcvd && !ev_pkt_dec) |=> flags[6]);
endmodule

bind nic_irq_aggr nic_irq_aggr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_n       (irq_n),
  .en_q        (en_q),
  .flags       (flags),
  .pkt_cnt     (pkt_cnt),
  .phy_flg     (phy_flg),
  .phy_rd      (phy_rd),
  .ev_pkt_rcvd (ev_pkt_rcvd),
  .ev_pkt_dec  (ev_pkt_dec),
  .ev_dma_done (ev_dma_done),
  .ev_link_chg (ev_link_chg)
);

// File: tb/test_nic_irq_aggr.sv
`timescale 1ns/1ps
module test_nic_irq_aggr;
  logic        clk;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        ev_rx_nospace, ev_pkt_rcvd, ev_pkt_dec, ev_tx_err;
  logic        ev_tx_done, ev_dma_done, ev_link_chg;
  logic        irq_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] data;
    logic [2:0]  addr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // event bits: 0 nospace, 1 pkt, 2 dec, 3 txerr, 4 txdone, 5 dma, 6 link
  localparam logic [6:0] E_NOSP = 7'h01, E_PKT = 7'h02, E_DEC = 7'h04,
                         E_TXE = 7'h08, E_TXD = 7'h10, E_DMA = 7'h20,
                         E_LNK = 7'h40;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  nic_irq_aggr i_nic_irq_aggr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_rx_nospace(ev_rx_nospace), .ev_pkt_rcvd(ev_pkt_rcvd),
    .ev_pkt_dec(ev_pkt_dec), .ev_tx_err(ev_tx_err), .ev_tx_done(ev_tx_done),
    .ev_dma_done(ev_dma_done), .ev_link_chg(ev_link_chg), .irq_n(irq_n)
  );

  // Driver: one access / event set per cycle, driven just after the edge
  task automatic step(input logic [6:0] ev, input int op, input logic [2:0] a,
                      input logic [15:0] wd, input logic [15:0] exp, input string tag);
    exp_t item;
    @(posedge clk); #2;
    {ev_link_chg, ev_dma_done, ev_tx_done, ev_tx_err, ev_pkt_dec, ev_pkt_rcvd, ev_rx_nospace} = ev;
    reg_wr    = (op == 1);
    reg_rd    = (op == 2);
    reg_addr  = a;
    reg_wdata = wd;
    if (op == 2) begin
      item.data = exp; item.addr = a; item.tag = tag;
      sb.push_back(item);
    end
  endtask

  task automatic idle();
    step(7'h0, 0, 3'd0, 16'h0, 16'h0, "");
  endtask
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    step(7'h0, 1, a, d, 16'h0, "");
  endtask
  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    step(7'h0, 2, a, 16'h0, e, tag);
  endtask
  task automatic fire(input logic [6:0] ev);
    step(ev, 0, 3'd0, 16'h0, 16'h0, "");
  endtask

  task automatic chk_irq(input logic e, input string tag);
    idle();
    @(negedge clk);
    checks++;
    if (irq_n !== e) begin
      failures++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", tag, irq_n, e);
    end
  endtask

  // Monitor: pops an expected item for every read cycle
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      exp_t item;
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL scoreboard underflow actual=%h expected=none", reg_rdata);
      end else begin
        item = sb.pop_front();
        if (reg_rdata !== item.data) begin
          failures++;
          $display("FAIL %s addr=%0d actual=%h expected=%h",
                   item.tag, item.addr, reg_rdata, item.data);
        end
      end
    end
  end

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {ev_link_chg, ev_dma_done, ev_tx_done, ev_tx_err, ev_pkt_dec, ev_pkt_rcvd, ev_rx_nospace} = '0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, 16'h0000, "R1 enable");
    rd(3'd1, 16'h0000, "R1 flags");
    rd(3'd2, 16'h0000, "R1 status");
    rd(3'd3, 16'h0000, "R1 phy_en");
    rd(3'd4, 16'h0000, "R1 phy_flg");
    rd(3'd5, 16'h0000, "R1 count");
    chk_irq(1'b1, "R1 irq");

    // R11 reserved bits
    wr(3'd0, 16'hFFFF);
    rd(3'd0, 16'h00FB, "R11 enable bit2");
    wr(3'd0, 16'h0000);

    // R4 hardware sets
    fire(E_TXD | E_DMA | E_TXE | E_NOSP);
    rd(3'd1, 16'h002B, "R4 set flags");
    rd(3'd2, 16'h0000, "R3 status no enables");
    wr(3'd0, 16'h002B);
    rd(3'd2, 16'h0080, "R3 status global off");
    chk_irq(1'b1, "R2 global off");
    wr(3'd0, 16'h00AB);
    chk_irq(1'b0, "R2 asserted");
    wr(3'd1, 16'h000A);
    rd(3'd1, 16'h0021, "R4 partial clear");
    wr(3'd1, 16'h0021);
    rd(3'd1, 16'h0000, "R4 full clear");
    rd(3'd2, 16'h0000, "R3 status cleared");
    chk_irq(1'b1, "R2 deasserted");

    // R5 set beats clear
    step(E_DMA, 1, 3'd1, 16'h0020, 16'h0, "");
    rd(3'd1, 16'h0020, "R5 set wins");
    wr(3'd1, 16'h0020);
    rd(3'd1, 16'h0000, "R5 later clear");

    // R6 packet pending
    fire(E_PKT); fire(E_PKT);
    rd(3'd5, 16'h0002, "R6 count 2");
    rd(3'd1, 16'h0040, "R6 pending");
    chk_irq(1'b1, "R2 pkt not enabled");
    wr(3'd0, 16'h00C0);
    chk_irq(1'b0, "R2 pkt enabled");
    wr(3'd1, 16'h00FF);
    rd(3'd1, 16'h0040, "R6 write ignored");
    fire(E_DEC);
    rd(3'd1, 16'h0040, "R6 still pending");
    fire(E_DEC);
    rd(3'd1, 16'h0000, "R6 drained");
    fire(E_DEC);
    rd(3'd5, 16'h0000, "R6 dec at zero");
    chk_irq(1'b1, "R6 irq after drain");

    // R8/R9 PHY path
    wr(3'd0, 16'h0000);
    fire(E_LNK);
    rd(3'd1, 16'h0000, "R8 no main flag w/o phy enables");
    rd(3'd4, 16'h0010, "R9 link only");
    rd(3'd4, 16'h0000, "R9 self clear");
    wr(3'd3, 16'hFFFF);
    rd(3'd3, 16'h0012, "R11 phy enable mask");
    fire(E_LNK);
    rd(3'd1, 16'h0010, "R8 main link set");
    wr(3'd1, 16'h00FF);
    rd(3'd1, 16'h0010, "R8 write ignored");
    wr(3'd0, 16'h0090);
    chk_irq(1'b0, "R2 link enabled");
    rd(3'd4, 16'h0014, "R9 both flags");
    rd(3'd1, 16'h0000, "R8 cleared by phy read");
    rd(3'd4, 16'h0000, "R9 cleared");
    chk_irq(1'b1, "R8 irq after phy read");

    // R10 simultaneous link change and PHY read
    step(E_LNK, 2, 3'd4, 16'h0, 16'h0000, "R10 old value");
    rd(3'd1, 16'h0010, "R10 main relatched");
    rd(3'd4, 16'h0014, "R10 phy relatched");
    rd(3'd1, 16'h0000, "R10 cleared");

    // R7 saturation
    wr(3'd0, 16'h0081);
    for (int i = 0; i < 255; i++) fire(E_PKT);
    rd(3'd5, 16'h00FF, "R7 count 255");
    rd(3'd1, 16'h0040, "R7 no error yet");
    fire(E_PKT);
    rd(3'd5, 16'h00FF, "R7 saturated");
    rd(3'd1, 16'h0041, "R7 rx error on full");
    chk_irq(1'b0, "R7 irq");
    fire(E_PKT | E_DEC);
    rd(3'd5, 16'h00FE, "R7 inc+dec at full");
    wr(3'd1, 16'h0001);
    rd(3'd1, 16'h0040, "R7 rx error cleared");
    fire(E_NOSP);
    rd(3'd1, 16'h0041, "R7 nospace error");
    idle(); idle();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule